// File: doc/BRIEF.md
# Gate Drive Command and Miller Clamp Sequencer

This block turns a pair of drive inputs into three exclusive enables for a power switch output stage: a turn-on path, a turn-off path and a Miller clamp switch. The two drive inputs combine into one effective command. The positive input works as plain logic while the negative input is low. The negative input works as inverted logic while the positive input is high. An inhibit input comes from the fault and readiness logic next to this block. While it is high, the command is forced low and the gate is held off.

Every change between the on path and the off path passes through a programmable all-off dead interval, so the two paths never conduct together. The clamp switch is not simply the off command. It stays open when the turn-off begins. It latches closed only after the synchronized "gate below clamp threshold" comparator bit reports the gate has fallen, while the command is low and the off path is active. It then holds for the rest of the off interval and releases only on the next low-to-high edge of the command.

Top module: `gate_cmd_seq`

## Requirements
- R1: The effective command is high only when `drv_pos` = 1, `drv_neg` = 0 and `inhibit` = 0. Every other input combination keeps the off path enabled.
- R2: While `inhibit` is high, the drive inputs cannot turn the gate on. If `inhibit` rises while the on path is enabled, the block leaves the on state through the dead interval and reaches the off path.
- R3: `en_on` and `en_off` are never high in the same cycle.
- R4: Each change between the on path and the off path inserts exactly `DEAD_CYCLES` cycles with all three enables low. The first all-off cycle follows the clock edge that samples the command change.
- R5: At the start of each off interval `en_clamp` is low. The comparator bit `gate_low` passes through a two-flop synchronizer. `en_clamp` rises on the third rising clock edge after `gate_low` goes high, provided the off path is enabled and the command is low.
- R6: Once latched, `en_clamp` stays high for the rest of the off interval, even after `gate_low` returns low.
- R7: `en_clamp` clears only on a low-to-high change of the effective command. It is low after the edge that samples that change, before `en_on` rises. A rising `drv_pos` while `inhibit` is high is not such a change.
- R8: `en_clamp` is never high while `en_on` is high, and `gate_low` has no effect while the command is high.
- R9: While reset (`rst_n` low) is applied and right after it is released, `en_off` = 1, `en_on` = 0 and `en_clamp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_pos | input | 1 | Non-inverting drive input |
| drv_neg | input | 1 | Inverting drive input |
| inhibit | input | 1 | Hold gate off (fault, not ready or reset held) |
| gate_low | input | 1 | Asynchronous comparator bit: gate below clamp threshold |
| en_on | output | 1 | Turn-on path enable |
| en_off | output | 1 | Turn-off path enable |
| en_clamp | output | 1 | Miller clamp switch enable |

## Verification
All eight combinations of `drv_pos`, `drv_neg` and `inhibit` are applied from the off state. Each is checked through the dead interval and, where it applies, into the on state and back. This separates the decode truth table from the dead-time sequencing. The clamp is tested with three comparator patterns: a comparator rise during the off interval, which measures the synchronizer latency edge by edge; a comparator that is already high before turn-off, which shows the clamp waits for the off path; and a comparator pulse during the on state, which must leave no effect. The release of the clamp is tested with a command rise that the inhibit input masks and with a real command rise. This tells a clear caused by the raw input apart from a clear caused by the effective command.

// File: rtl/gate_cmd_seq.sv
module gate_cmd_seq #(
  parameter int DEAD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_pos,
  input  logic drv_neg,
  input  logic inhibit,
  input  logic gate_low,
  output logic en_on,
  output logic en_off,
  output logic en_clamp
);

  localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYCLES - 1);

  typedef enum logic [1:0] {ST_OFF, ST_DEAD, ST_ON} state_t;

  state_t st, st_nx;
  logic [CW-1:0] cnt;
  logic [1:0] sync_q;
  logic cmd_w, cmd_q, cmd_rise, clamp_q;

  assign cmd_w    = drv_pos & ~drv_neg & ~inhibit;
  assign cmd_rise = cmd_w & ~cmd_q;

  always_comb begin
    st_nx = st;
    case (st)
      ST_OFF:  if (cmd_w) st_nx = ST_DEAD;
      ST_ON:   if (!cmd_w) st_nx = ST_DEAD;
      ST_DEAD: if (cnt == LAST) st_nx = cmd_w ? ST_ON : ST_OFF;
      default: st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      cnt     <= '0;
      sync_q  <= '0;
      cmd_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      st     <= st_nx;
      cnt    <= (st == ST_DEAD && cnt != LAST) ? cnt + 1'b1 : '0;
      sync_q <= {sync_q[0], gate_low};
      cmd_q  <= cmd_w;
      if (cmd_rise)
        clamp_q <= 1'b0;
      else if (st == ST_OFF && !cmd_w && sync_q[1])
        clamp_q <= 1'b1;
    end
  end

  assign en_on    = (st == ST_ON);
  assign en_off   = (st == ST_OFF);
  assign en_clamp = clamp_q & ~en_on;

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_on && en_off));

  assert_dead_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_on) |-> $past(!en_off));

  assert_dead_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_off) |-> $past(!en_on));

  assert_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !$rose(en_on));

  assert_clamp_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_clamp && en_on));

  assert_clamp_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_clamp) |-> $past(en_off && !cmd_w));

  assert_clamp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_clamp) |-> $past(cmd_w));

endmodule

// File: tb/sim_gate_cmd_seq.sv
module sim_gate_cmd_seq;
  localparam int PERIOD = 10;
  localparam int DC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic drv_pos = 1'b0, drv_neg = 1'b0, inhibit = 1'b0, gate_low = 1'b0;
  logic en_on, en_off, en_clamp;
  int runs = 0, fails = 0;

  gate_cmd_seq #(.DEAD_CYCLES(DC)) u0 (
    .clk(clk), .rst_n(rst_n), .drv_pos(drv_pos), .drv_neg(drv_neg),
    .inhibit(inhibit), .gate_low(gate_low),
    .en_on(en_on), .en_off(en_off), .en_clamp(en_clamp));

  always #(PERIOD/2) clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [2:0] expv);
    runs++;
    if ({en_on, en_off, en_clamp} !== expv) begin
      fails++;
      $display("FAIL %s: {on,off,clamp} got %b expected %b", req, {en_on, en_off, en_clamp}, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R9 in reset", 3'b010);
    step(2);
    rst_n = 1'b1;
    step();
    chk("R9 after reset", 3'b010);

    // R1/R2 sweep of all input combinations from the off state
    for (int v = 0; v < 8; v++) begin
      logic c;
      drv_pos = v[0]; drv_neg = v[1]; inhibit = v[2];
      c = v[0] & ~v[1] & ~v[2];
      for (int k = 1; k <= DC; k++) begin
        step();
        chk(c ? "R4 dead to on" : "R1 stays off", c ? 3'b000 : 3'b010);
      end
      step();
      chk(c ? "R1 on" : "R2/R1 off", c ? 3'b100 : 3'b010);
      drv_pos = 1'b0; drv_neg = 1'b0; inhibit = 1'b0;
      step();
      chk(c ? "R4 dead to off" : "R1 off hold", c ? 3'b000 : 3'b010);
      step(DC);
      chk("R3 back off", 3'b010);
    end

    // R2: inhibit during on
    drv_pos = 1'b1;
    step(DC + 1);
    chk("R1 on again", 3'b100);
    inhibit = 1'b1;
    step();
    chk("R2 leave on", 3'b000);
    step(DC);
    chk("R2 off", 3'b010);
    step(4);
    chk("R2 held off", 3'b010);
    inhibit = 1'b0;
    step(DC + 1);
    chk("R1 on after inhibit", 3'b100);

    // R8: comparator while on has no effect
    gate_low = 1'b1;
    step(5);
    chk("R8 ignore comparator on", 3'b100);
    gate_low = 1'b0;
    step(3);

    // R5: turn off, clamp initially off, then latency 3 edges
    drv_pos = 1'b0;
    step(DC + 1);
    chk("R5 off no clamp", 3'b010);
    step(3);
    chk("R5 still no clamp", 3'b010);
    gate_low = 1'b1;
    step(2);
    chk("R5 clamp after 2 edges", 3'b010);
    step();
    chk("R5 clamp after 3 edges", 3'b011);

    // R6: hold after comparator drops
    gate_low = 1'b0;
    step(6);
    chk("R6 clamp held", 3'b011);

    // R7: masked rise does not clear
    inhibit = 1'b1; drv_pos = 1'b1;
    step(3);
    chk("R7 masked rise", 3'b011);
    inhibit = 1'b0;
    step();
    chk("R7 clear on rise", 3'b000);
    step(DC);
    chk("R7 on no clamp", 3'b100);

    // R5: comparator already high before turn-off
    gate_low = 1'b1;
    step(3);
    drv_pos = 1'b0; drv_neg = 1'b0;
    step(DC + 1);
    chk("R5 first off cycle", 3'b010);
    step();
    chk("R5 clamp latched", 3'b011);

    // R1: negative logic on drv_neg with drv_pos high
    drv_pos = 1'b1; drv_neg = 1'b1;
    step(DC + 2);
    chk("R1 neg high keeps off", 3'b011);
    drv_neg = 1'b0;
    step();
    chk("R7 clear via neg input", 3'b000);
    step(DC);
    chk("R1 on via neg low", 3'b100);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule